// File: doc/BRIEF.md
# Paged Memory Write Buffer Controller

This block sits between a command engine and two simple nonvolatile memory models: a program store holding 16-bit words and a data store holding bytes. Load commands fill a page buffer one element at a time. A commit command then copies the buffered page into the selected page of the array. A single-byte write command updates one data location directly. After every commit or byte write the controller is busy for a wait time set in clock cycles. During that time it turns away every request that would modify anything. A read during that time returns the busy flag instead of array contents.

The controller is built around a state machine with six named states. S_IDLE accepts commands. S_COPY_P moves one buffered word per cycle into the program array. S_COPY_D merges the loaded data bytes into one data page in a single cycle. S_ERASE sets the target byte to all ones. S_BYTE writes the new value into that byte. S_WAIT holds the busy period. The transitions are:
- S_IDLE to S_COPY_P on a program commit.
- S_IDLE to S_COPY_D on a data commit.
- S_IDLE to S_ERASE on a byte write.
- S_COPY_P to S_WAIT after the last word.
- S_COPY_D to S_WAIT after one cycle.
- S_ERASE to S_BYTE after one cycle.
- S_BYTE to S_WAIT after one cycle.
- S_WAIT to S_IDLE when the wait counter reaches zero.

Command codes on `cmd_op`:

| Code | Command |
|---|---|
| 1 | load program low byte |
| 2 | load program high byte |
| 3 | program commit |
| 4 | load data byte |
| 5 | data commit |
| 6 | byte write |
| 8 | read program low byte |
| 9 | read program high byte |
| 10 | read data byte |

Any other code is ignored.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset `busy`, `err_busy`, `err_order` and `rsp_valid` are 0. Every location of both arrays reads 0xFF.
- R2: A program load (code 1 low byte, code 2 high byte) places its byte in the buffer word selected by `cmd_addr[POFF_W-1:0]`. A program commit (code 3) writes the buffer to the page given by `cmd_addr[POFF_W +: PPAGE_W]`, where word address = page × 2^POFF_W + offset. A read of that word afterwards returns the loaded bytes.
- R3: A high-byte load to a buffer word whose low byte has not been loaded since the last commit pulses `err_order` for one cycle, in the cycle after acceptance. It leaves that word unchanged. A later commit then writes 0xFFFF there.
- R4: A program commit writes the whole page. Words not loaded since the last commit become 0xFFFF. The buffer is cleared after every commit, so a commit with no loads erases the page.
- R5: A data load (code 4) places a byte at buffer offset `cmd_addr[1:0]`. A data commit (code 5) writes to page `cmd_addr[5:2]`, where byte address = page × 4 + offset. Only the offsets loaded since the last commit change; the other bytes of the page keep their old contents.
- R6: A byte write (code 6) to byte address `cmd_addr[5:0]` erases the location and then writes `cmd_data`. The location ends up holding exactly `cmd_data`, even where the old value had a 0 and the new value has a 1.
- R7: `busy` rises in the cycle after a commit or byte write is accepted. It stays high for the following number of cycles:
  - program commit: 2^POFF_W + T_WAIT_P;
  - data commit: 1 + T_WAIT_D;
  - byte write: 2 + T_WAIT_D.
- R8: A load, commit or byte write issued while `busy` is high pulses `err_busy` in the next cycle. It changes neither array nor either buffer.
- R9: A read (code 8, 9 or 10) gives `rsp_valid` for one cycle, in the cycle after the request, with the addressed byte on `rsp_data`. A read made while `busy` is high returns 0x01 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Word address (program commands) or byte address (data commands) |
| cmd_data | input | 8 | Byte to load or write |
| busy | output | 1 | High while a commit or byte write is in progress |
| err_busy | output | 1 | One-cycle pulse: a request was rejected because the block was busy |
| err_order | output | 1 | One-cycle pulse: a high byte was loaded before its low byte |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 8 | Read response byte |

## Verification
The hardest situation to reach is a request that lands inside the busy window and must leave no trace. That window exists only after a commit is accepted. Its trace could lie in an array or in a buffer that is never read directly.

The stimulus starts a program commit, then issues a data load, a byte write, a program load and a read in the cycles that follow. Once idle, it reads the targeted bytes back. It then commits with no loads in between, so that any byte the rejected loads slipped into a buffer would reach an array and be seen.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDPL = 4'd1,
        OP_LDPH = 4'd2,
        OP_CMTP = 4'd3,
        OP_LDD  = 4'd4,
        OP_CMTD = 4'd5,
        OP_WRD  = 4'd6,
        OP_RDPL = 4'd8,
        OP_RDPH = 4'd9,
        OP_RDD  = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COPY_P,
        S_COPY_D,
        S_ERASE,
        S_BYTE,
        S_WAIT
    } state_e;

    function automatic logic op_modifies(input logic [3:0] op);
        return (op >= 4'd1) && (op <= 4'd6);
    endfunction

    function automatic logic op_reads(input logic [3:0] op);
        return (op >= 4'd8) && (op <= 4'd10);
    endfunction

endpackage

// File: rtl/pwb_prog_buf.sv
module pwb_prog_buf #(
    parameter int OFF_W = 6,
    localparam int WORDS = 1 << OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [OFF_W-1:0] ld_idx,
    input  logic [7:0]       ld_data,
    input  logic             clr,
    input  logic [OFF_W-1:0] rd_idx,
    output logic [15:0]      rd_word,
    output logic             order_bad
);

    logic [15:0]      words [WORDS];
    logic [WORDS-1:0] lo_seen;

    // A high byte is refused while its low byte is still missing.
    assign order_bad = ld_hi && !lo_seen[ld_idx];
    assign rd_word   = words[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < WORDS; i++) begin
                words[i] <= 16'hFFFF;
            end
            lo_seen <= '0;
        end else if (ld_lo) begin
            words[ld_idx][7:0] <= ld_data;
            lo_seen[ld_idx]    <= 1'b1;
        end else if (ld_hi && lo_seen[ld_idx]) begin
            words[ld_idx][15:8] <= ld_data;
        end
    end

endmodule

// File: rtl/pwb_data_buf.sv
module pwb_data_buf #(
    parameter int OFF_W = 2,
    localparam int BYTES = 1 << OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld,
    input  logic [OFF_W-1:0]      ld_idx,
    input  logic [7:0]            ld_data,
    input  logic                  clr,
    output logic [BYTES-1:0][7:0] bytes_o,
    output logic [BYTES-1:0]      mask_o
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bytes_o <= '1;
            mask_o  <= '0;
        end else if (ld) begin
            bytes_o[ld_idx] <= ld_data;
            mask_o[ld_idx]  <= 1'b1;
        end
    end

endmodule

// File: rtl/pwb_wait_timer.sv
module pwb_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int POFF_W   = 6,
    parameter int PPAGE_W  = 2,
    parameter int DOFF_W   = 2,
    parameter int DPAGE_W  = 4,
    parameter int T_WAIT_P = 200,
    parameter int T_WAIT_D = 100,
    localparam int PA_W   = POFF_W + PPAGE_W,
    localparam int DA_W   = DOFF_W + DPAGE_W,
    localparam int ADDR_W = (PA_W > DA_W) ? PA_W : DA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              busy,
    output logic              err_busy,
    output logic              err_order,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data
);

    localparam int PWORDS  = 1 << PA_W;
    localparam int DBYTES  = 1 << DA_W;
    localparam int DPB     = 1 << DOFF_W;
    localparam int TMAX    = (T_WAIT_P > T_WAIT_D) ? T_WAIT_P : T_WAIT_D;
    localparam int CNT_W   = $clog2(TMAX + 1);
    localparam logic [POFF_W-1:0] LAST_IDX = '1;

    state_e state, state_nx;
    op_e    op;
    logic   accept;

    logic [15:0]            prog_mem [PWORDS];
    logic [7:0]             data_mem [DBYTES];

    logic [PPAGE_W-1:0]     page_q;
    logic [DPAGE_W-1:0]     dpage_q;
    logic [DA_W-1:0]        daddr_q;
    logic [7:0]             dbyte_q;
    logic [POFF_W-1:0]      idx_q;

    logic [15:0]            pb_word;
    logic                   pb_order_bad;
    logic                   pb_clr;
    logic [DPB-1:0][7:0]    db_bytes;
    logic [DPB-1:0]         db_mask;
    logic                   db_clr;
    logic                   tmr_load;
    logic [CNT_W-1:0]       tmr_val;
    logic                   tmr_done;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && (state == S_IDLE);
    assign busy   = (state != S_IDLE);
    assign pb_clr = (state == S_COPY_P) && (idx_q == LAST_IDX);
    assign db_clr = (state == S_COPY_D);

    pwb_prog_buf #(.OFF_W(POFF_W)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_lo     (accept && op == OP_LDPL),
        .ld_hi     (accept && op == OP_LDPH),
        .ld_idx    (cmd_addr[POFF_W-1:0]),
        .ld_data   (cmd_data),
        .clr       (pb_clr),
        .rd_idx    (idx_q),
        .rd_word   (pb_word),
        .order_bad (pb_order_bad)
    );

    pwb_data_buf #(.OFF_W(DOFF_W)) u_dbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (accept && op == OP_LDD),
        .ld_idx  (cmd_addr[DOFF_W-1:0]),
        .ld_data (cmd_data),
        .clr     (db_clr),
        .bytes_o (db_bytes),
        .mask_o  (db_mask)
    );

    pwb_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state and timer load
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(T_WAIT_D - 1);
        unique case (state)
            S_IDLE: begin
                if (accept && op == OP_CMTP)      state_nx = S_COPY_P;
                else if (accept && op == OP_CMTD) state_nx = S_COPY_D;
                else if (accept && op == OP_WRD)  state_nx = S_ERASE;
            end
            S_COPY_P: begin
                if (idx_q == LAST_IDX) begin
                    state_nx = S_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_WAIT_P - 1);
                end
            end
            S_COPY_D: begin
                state_nx = S_WAIT;
                tmr_load = 1'b1;
            end
            S_ERASE: state_nx = S_BYTE;
            S_BYTE: begin
                state_nx = S_WAIT;
                tmr_load = 1'b1;
            end
            S_WAIT: begin
                if (tmr_done) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs, arrays and captured command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PWORDS; i++) prog_mem[i] <= 16'hFFFF;
            for (int i = 0; i < DBYTES; i++) data_mem[i] <= 8'hFF;
            page_q    <= '0;
            dpage_q   <= '0;
            daddr_q   <= '0;
            dbyte_q   <= '0;
            idx_q     <= '0;
            err_busy  <= 1'b0;
            err_order <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            err_busy  <= cmd_valid && busy && op_modifies(cmd_op);
            err_order <= accept && pb_order_bad;
            rsp_valid <= cmd_valid && op_reads(cmd_op);
            if (cmd_valid && op_reads(cmd_op)) begin
                if (busy)                 rsp_data <= 8'h01;
                else if (op == OP_RDPL)   rsp_data <= prog_mem[cmd_addr[PA_W-1:0]][7:0];
                else if (op == OP_RDPH)   rsp_data <= prog_mem[cmd_addr[PA_W-1:0]][15:8];
                else                      rsp_data <= data_mem[cmd_addr[DA_W-1:0]];
            end
            if (accept) begin
                page_q  <= cmd_addr[POFF_W +: PPAGE_W];
                dpage_q <= cmd_addr[DOFF_W +: DPAGE_W];
                daddr_q <= cmd_addr[DA_W-1:0];
                dbyte_q <= cmd_data;
                idx_q   <= '0;
            end
            unique case (state)
                S_COPY_P: begin
                    prog_mem[{page_q, idx_q}] <= pb_word;
                    idx_q <= idx_q + 1'b1;
                end
                S_COPY_D: begin
                    for (int i = 0; i < DPB; i++) begin
                        if (db_mask[i]) data_mem[{dpage_q, DOFF_W'(i)}] <= db_bytes[i];
                    end
                end
                S_ERASE: data_mem[daddr_q] <= 8'hFF;
                S_BYTE:  data_mem[daddr_q] <= dbyte_q;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       busy,
    input logic       err_busy,
    input logic       err_order,
    input logic       rsp_valid,
    input logic [7:0] rsp_data
);

    a_r8_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy && cmd_op >= 4'd1 && cmd_op <= 4'd6) |=> err_busy);

    a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |-> ($past(busy) && $past(cmd_valid)));

    a_r3_order_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_order |-> !$past(busy));

    a_r9_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(busy)) |-> (rsp_data == 8'h01));

    a_r9_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid));

    a_r7_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

endmodule

bind pwb_ctrl pwb_ctrl_chk u_chk (.*);

// File: tb/sim_pwb_ctrl.sv
module sim_pwb_ctrl;

    localparam int POFF_W = 6;
    localparam int PPAGE_W = 2;
    localparam int TP = 20;
    localparam int TD = 5;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          busy, err_busy, err_order, rsp_valid;
    logic [7:0]    rsp_data;

    int checks_n = 0;
    int fails_n  = 0;
    logic last_eb, last_eo;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    pwb_ctrl #(.POFF_W(POFF_W), .PPAGE_W(PPAGE_W), .T_WAIT_P(TP), .T_WAIT_D(TD)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .err_busy(err_busy),
        .err_order(err_order), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks_n++;
        if (!ok) begin
            fails_n++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input int addr, input logic [7:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr[AW-1:0];
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = '0;
        last_eb   = err_busy;
        last_eo   = err_order;
    endtask

    task automatic rd(input logic [3:0] op, input int addr, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issue(op, addr, 8'h00);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", rsp_data, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rsp_data == e, t, rsp_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && err_busy == 0 && err_order == 0 && rsp_valid == 0,
              "R1 idle outputs", {busy, err_busy, err_order, rsp_valid}, 0);
        rd(4'd8, 0,   8'hFF, "R1 prog low erased");
        rd(4'd9, 255, 8'hFF, "R1 prog high erased");
        rd(4'd10, 0,  8'hFF, "R1 data erased");
        rd(4'd10, 63, 8'hFF, "R1 data top erased");

        // R2 program page load and commit
        issue(4'd1, 0, 8'h34);  issue(4'd2, 0, 8'h12);
        issue(4'd1, 63, 8'hCD); issue(4'd2, 63, 8'hAB);
        check(last_eo == 0, "R3 ordered load no error", last_eo, 0);
        issue(4'd3, 64, 8'h00);
        busy_len(n);
        check(n == 64 + TP, "R7 program busy length", n, 64 + TP);
        rd(4'd8, 64, 8'h34, "R2 word64 low");
        rd(4'd9, 64, 8'h12, "R2 word64 high");
        rd(4'd8, 127, 8'hCD, "R2 word127 low");
        rd(4'd9, 127, 8'hAB, "R2 word127 high");
        rd(4'd8, 65, 8'hFF, "R4 unloaded word low");
        rd(4'd9, 65, 8'hFF, "R4 unloaded word high");

        // R3 ordering
        issue(4'd2, 5, 8'h55);
        check(last_eo == 1, "R3 high before low flagged", last_eo, 1);
        issue(4'd1, 5, 8'h77);
        check(last_eo == 0, "R3 low load no error", last_eo, 0);
        issue(4'd2, 5, 8'h88);
        check(last_eo == 0, "R3 high after low no error", last_eo, 0);
        issue(4'd2, 6, 8'h99);
        check(last_eo == 1, "R3 lone high flagged", last_eo, 1);
        issue(4'd3, 128, 8'h00);
        wait_idle();
        rd(4'd8, 133, 8'h77, "R3 word133 low");
        rd(4'd9, 133, 8'h88, "R3 word133 high");
        rd(4'd9, 134, 8'hFF, "R3 rejected high unchanged");

        // R4 buffer cleared: empty commit erases page 1
        issue(4'd3, 64, 8'h00);
        wait_idle();
        rd(4'd8, 64, 8'hFF, "R4 empty commit low");
        rd(4'd9, 127, 8'hFF, "R4 empty commit high");

        // R6 byte writes
        issue(4'd6, 12, 8'h11);
        busy_len(n);
        check(n == 2 + TD, "R7 byte write busy length", n, 2 + TD);
        issue(4'd6, 13, 8'h22); wait_idle();
        issue(4'd6, 14, 8'h33); wait_idle();
        issue(4'd6, 15, 8'h44); wait_idle();
        issue(4'd6, 20, 8'h0F); wait_idle();
        issue(4'd6, 20, 8'hF0); wait_idle();
        rd(4'd10, 20, 8'hF0, "R6 erase then write");
        rd(4'd10, 13, 8'h22, "R6 byte write value");

        // R5 data page merge
        issue(4'd4, 13, 8'hAA);
        issue(4'd4, 15, 8'hBB);
        issue(4'd5, 12, 8'h00);
        busy_len(n);
        check(n == 1 + TD, "R7 data commit busy length", n, 1 + TD);
        rd(4'd10, 12, 8'h11, "R5 unloaded byte kept");
        rd(4'd10, 13, 8'hAA, "R5 loaded byte");
        rd(4'd10, 14, 8'h33, "R5 unloaded byte kept");
        rd(4'd10, 15, 8'hBB, "R5 loaded byte");

        // R8 rejection while busy
        issue(4'd3, 0, 8'h00);
        issue(4'd4, 12, 8'h55);
        check(last_eb == 1, "R8 data load rejected", last_eb, 1);
        issue(4'd6, 14, 8'h00);
        check(last_eb == 1, "R8 byte write rejected", last_eb, 1);
        issue(4'd1, 0, 8'h66);
        check(last_eb == 1, "R8 program load rejected", last_eb, 1);
        rd(4'd10, 12, 8'h01, "R9 read while busy");
        check(last_eb == 0, "R8 read not flagged", last_eb, 0);
        wait_idle();
        rd(4'd10, 12, 8'h11, "R8 array untouched");
        rd(4'd10, 14, 8'h33, "R8 byte write dropped");
        issue(4'd5, 12, 8'h00); wait_idle();
        rd(4'd10, 12, 8'h11, "R8 data buffer untouched");
        issue(4'd3, 0, 8'h00); wait_idle();
        rd(4'd8, 0, 8'hFF, "R8 program buffer untouched");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
        $finish;
    end

endmodule